// File: doc/BRIEF.md
# Bidirectional LCD Row-Scan Driver

This block generates the row-select pattern for a passive-matrix LCD panel. It is a 240-stage scan shift register that advances on every falling edge of the line clock. A start token enters through one of two cascade links; a direction input picks which link is the entry and which one passes the token on to the next driver in a chain. Each stage drives one row output.

Each row output is reduced to a 2-bit drive-level code. The code is chosen from the stage's selection bit and a frame-inversion input. An active-low blanking input forces every row to ground level and empties the register at once. Capture starts again only at the line-clock falling edge that follows the release of blanking. Analog level shifting, bias generation and pin pull-downs belong to the pad ring, not to this block.

Top module: `lcd_row_driver`

## Requirements
- R1: While rst_ni is low, no stage is selected and both link outputs are high; with inv_i low every row reads code 2'b10.
- R2: Row code for stage k sits at lvl_o[2k+1:2k]. Selected with inv_i=1 gives 2'b11 (top level). Selected with inv_i=0 gives 2'b00 (ground). Non-selected with inv_i=1 gives 2'b01 (lower-middle). Non-selected with inv_i=0 gives 2'b10 (upper-middle).
- R3: With dir_i high, a low on link_a_i at a line-clock falling edge selects stage 0. Each later falling edge moves the selection from stage k to stage k+1.
- R4: With dir_i low, a low on link_b_i at a falling edge selects stage 239. Each later falling edge moves the selection from stage k to stage k-1.
- R5: With dir_i high, link A is the input (link_a_oe_o=0) and link B is the output (link_b_oe_o=1). With dir_i low the roles swap. A level on the link currently acting as output is ignored.
- R6: The outgoing link is low for exactly one line-clock period, from the 240th falling edge after capture to the 241st, and high otherwise.
- R7: While blank_ni is low, every row code is 2'b00 without waiting for a clock edge. The register is cleared, and a start token present at a falling edge is not captured.
- R8: After blank_ni rises, all rows show a non-select code (2'b01 or 2'b10 per inv_i). A start token is captured at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock; the register moves on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Scan direction: 1 = stage 0 upward, 0 = stage 239 downward |
| inv_i | input | 1 | Frame-inversion phase |
| blank_ni | input | 1 | Active-low blank: rows to ground, register cleared |
| link_a_i | input | 1 | Link A input level (active-low start) |
| link_a_o | output | 1 | Link A output level (active-low carry) |
| link_a_oe_o | output | 1 | Link A acts as output |
| link_b_i | input | 1 | Link B input level (active-low start) |
| link_b_o | output | 1 | Link B output level (active-low carry) |
| link_b_oe_o | output | 1 | Link B acts as output |
| lvl_o | output | 480 | Two-bit drive-level code per row, stage k at [2k+1:2k] |

## Verification
Row codes and link outputs change once per line-clock falling edge: a token present at edge n lands on its first stage at edge n and reaches the far link after edge n+239. The bench drives inputs a quarter period after each falling edge and samples just before it changes them again, so each result is read one register stage after its cause. Blanking and reset act without a clock, so they are checked a single time unit after the input moves. Level codes follow inv_i combinationally and are read in the same sample window.

// File: rtl/lcd_row_pkg.sv
package lcd_row_pkg;
  typedef enum logic [1:0] {
    LVL_GND    = 2'b00,
    LVL_MID_LO = 2'b01,
    LVL_MID_HI = 2'b10,
    LVL_TOP    = 2'b11
  } lvl_e;

  function automatic lvl_e lvl_pick(input logic sel, input logic inv, input logic blank);
    if (blank)    return LVL_GND;
    else if (sel) return inv ? LVL_TOP : LVL_GND;
    else          return inv ? LVL_MID_LO : LVL_MID_HI;
  endfunction
endpackage

// File: rtl/lcd_link_port.sv
module lcd_link_port (
  input  logic dir_i,
  input  logic link_a_i,
  input  logic link_b_i,
  input  logic tail_up_i,
  input  logic tail_dn_i,
  output logic start_o,
  output logic link_a_o,
  output logic link_a_oe_o,
  output logic link_b_o,
  output logic link_b_oe_o
);
  // active-low token on whichever link is the entry
  assign start_o     = dir_i ? ~link_a_i : ~link_b_i;
  assign link_b_oe_o = dir_i;
  assign link_a_oe_o = ~dir_i;
  assign link_b_o    = dir_i ? ~tail_up_i : 1'b1;
  assign link_a_o    = dir_i ? 1'b1 : ~tail_dn_i;
endmodule

// File: rtl/lcd_scan_reg.sv
module lcd_scan_reg #(
  parameter int unsigned N_STAGES = 240
) (
  input  logic                clk_i,
  input  logic                clr_ni,
  input  logic                dir_i,
  input  logic                start_i,
  output logic [N_STAGES-1:0] q_o
);
  logic [N_STAGES-1:0] nxt;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic up_src, dn_src;
    if (i == 0) begin : g_first
      assign up_src = start_i;
    end else begin : g_mid_up
      assign up_src = q_o[i-1];
    end
    if (i == N_STAGES-1) begin : g_last
      assign dn_src = start_i;
    end else begin : g_mid_dn
      assign dn_src = q_o[i+1];
    end
    assign nxt[i] = dir_i ? up_src : dn_src;
  end

  always_ff @(negedge clk_i or negedge clr_ni) begin
    if (!clr_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_row_pkg::*;
#(
  parameter int unsigned N_STAGES = 240
) (
  input  logic [N_STAGES-1:0]   sel_i,
  input  logic                  inv_i,
  input  logic                  blank_i,
  output logic [2*N_STAGES-1:0] lvl_o
);
  for (genvar i = 0; i < N_STAGES; i++) begin : g_row
    assign lvl_o[2*i +: 2] = lvl_pick(sel_i[i], inv_i, blank_i);
  end
endmodule

// File: rtl/lcd_row_driver.sv
module lcd_row_driver #(
  parameter int unsigned N_STAGES = 240,
  localparam int unsigned LVL_W = 2 * N_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             inv_i,
  input  logic             blank_ni,
  input  logic             link_a_i,
  output logic             link_a_o,
  output logic             link_a_oe_o,
  input  logic             link_b_i,
  output logic             link_b_o,
  output logic             link_b_oe_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [N_STAGES-1:0] q;
  logic start;
  logic clr_n;

  // blanking and reset both empty the register without a clock
  assign clr_n = rst_ni & blank_ni;

  lcd_link_port i_link (
    .dir_i       (dir_i),
    .link_a_i    (link_a_i),
    .link_b_i    (link_b_i),
    .tail_up_i   (q[N_STAGES-1]),
    .tail_dn_i   (q[0]),
    .start_o     (start),
    .link_a_o    (link_a_o),
    .link_a_oe_o (link_a_oe_o),
    .link_b_o    (link_b_o),
    .link_b_oe_o (link_b_oe_o)
  );

  lcd_scan_reg #(.N_STAGES(N_STAGES)) i_scan (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .dir_i   (dir_i),
    .start_i (start),
    .q_o     (q)
  );

  lcd_level_enc #(.N_STAGES(N_STAGES)) i_enc (
    .sel_i   (q),
    .inv_i   (inv_i),
    .blank_i (~blank_ni),
    .lvl_o   (lvl_o)
  );
endmodule

// File: rtl/lcd_row_driver_chk.sv
module lcd_row_driver_chk #(
  parameter int unsigned N_STAGES = 240
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  dir_i,
  input logic                  inv_i,
  input logic                  blank_ni,
  input logic                  link_a_i,
  input logic                  link_a_o,
  input logic                  link_a_oe_o,
  input logic                  link_b_i,
  input logic                  link_b_o,
  input logic                  link_b_oe_o,
  input logic [2*N_STAGES-1:0] lvl_o
);
  logic [N_STAGES-1:0] sel_v, lsb_v;
  always_comb begin
    for (int k = 0; k < N_STAGES; k++) begin
      sel_v[k] = ~(lvl_o[2*k+1] ^ lvl_o[2*k]);
      lsb_v[k] = lvl_o[2*k];
    end
  end

  // R2
  level_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_ni |-> lsb_v == {N_STAGES{inv_i}});
  // R3
  shift_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && $past(blank_ni) && $past(rst_ni) && dir_i && $past(dir_i))
    |-> (sel_v[N_STAGES-1:1] == $past(sel_v[N_STAGES-2:0])) && (sel_v[0] == !$past(link_a_i)));
  // R4
  shift_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && $past(blank_ni) && $past(rst_ni) && !dir_i && !$past(dir_i))
    |-> (sel_v[N_STAGES-2:0] == $past(sel_v[N_STAGES-1:1])) && (sel_v[N_STAGES-1] == !$past(link_b_i)));
  // R5
  oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_b_oe_o == dir_i) && (link_a_oe_o == !dir_i));
  // R6
  tail_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && dir_i) |-> (link_b_o == !sel_v[N_STAGES-1]) && link_a_o);
  // R6
  tail_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && !dir_i) |-> (link_a_o == !sel_v[0]) && link_b_o);
  // R7
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> (lvl_o == '0) && link_a_o && link_b_o);
endmodule

bind lcd_row_driver lcd_row_driver_chk #(.N_STAGES(N_STAGES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dir_i       (dir_i),
  .inv_i       (inv_i),
  .blank_ni    (blank_ni),
  .link_a_i    (link_a_i),
  .link_a_o    (link_a_o),
  .link_a_oe_o (link_a_oe_o),
  .link_b_i    (link_b_i),
  .link_b_o    (link_b_o),
  .link_b_oe_o (link_b_oe_o),
  .lvl_o       (lvl_o)
);

// File: tb/test_lcd_row_driver.sv
module test_lcd_row_driver;
  localparam int CLK_PERIOD = 10;
  localparam int N = 240;
  // {inv, token, expected stage-0 code}
  localparam logic [3:0] LVL_TAB [4] = '{4'b1111, 4'b0100, 4'b1001, 4'b0010};

  logic clk_i = 1'b0;
  logic rst_ni, dir_i, inv_i, blank_ni, link_a_i, link_b_i;
  logic link_a_o, link_a_oe_o, link_b_o, link_b_oe_o;
  logic [2*N-1:0] lvl_o;
  int n_chk = 0;
  int n_fail = 0;

  lcd_row_driver #(.N_STAGES(N)) i_lcd_row_driver (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .inv_i(inv_i), .blank_ni(blank_ni),
    .link_a_i(link_a_i), .link_a_o(link_a_o), .link_a_oe_o(link_a_oe_o),
    .link_b_i(link_b_i), .link_b_o(link_b_o), .link_b_oe_o(link_b_oe_o),
    .lvl_o(lvl_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int count_code(input logic [1:0] c);
    int n = 0;
    for (int k = 0; k < N; k++) if (lvl_o[2*k +: 2] == c) n++;
    return n;
  endfunction

  function automatic logic [1:0] code_at(input int k);
    return lvl_o[2*k +: 2];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edge_step();
    @(negedge clk_i);
    #(CLK_PERIOD/4);
  endtask

  // hold blank low across a rising edge so the register is empty
  task automatic clear_reg();
    blank_ni = 1'b0;
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    blank_ni = 1'b1;
  endtask

  task automatic walk(input bit up);
    int idx;
    dir_i = up;
    inv_i = 1'b1;
    clear_reg();
    if (up) link_a_i = 1'b0; else link_b_i = 1'b0;
    for (int k = 0; k < N; k++) begin
      edge_step();
      if (k == 0) begin link_a_i = 1'b1; link_b_i = 1'b1; end
      idx = up ? k : N-1-k;
      chk(code_at(idx) == 2'b11 && count_code(2'b11) == 1, up ? "R3" : "R4",
          "selected row", int'(code_at(idx)), 3);
      if (k == N-2)
        chk((up ? link_b_o : link_a_o) == 1'b1, "R6", "far link before end", int'(up ? link_b_o : link_a_o), 1);
      if (k == N-1) begin
        chk((up ? link_b_o : link_a_o) == 1'b0, "R6", "far link at end", int'(up ? link_b_o : link_a_o), 0);
        chk((up ? link_a_o : link_b_o) == 1'b1, "R5", "entry link idle", int'(up ? link_a_o : link_b_o), 1);
        chk(link_b_oe_o == up && link_a_oe_o == !up, "R5", "link roles", int'({link_a_oe_o, link_b_oe_o}), up ? 1 : 2);
      end
    end
    edge_step();
    chk((up ? link_b_o : link_a_o) == 1'b1, "R6", "far link released", int'(up ? link_b_o : link_a_o), 1);
    chk(count_code(2'b11) == 0, "R6", "register empty after exit", count_code(2'b11), 0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; blank_ni = 1'b1; dir_i = 1'b1; inv_i = 1'b0;
    link_a_i = 1'b1; link_b_i = 1'b1;
    #(2*CLK_PERIOD + CLK_PERIOD/4);
    // R1 reset state
    chk(count_code(2'b10) == N, "R1", "rows at upper-middle", count_code(2'b10), N);
    chk(link_a_o && link_b_o, "R1", "links high", int'({link_a_o, link_b_o}), 3);
    rst_ni = 1'b1;
    edge_step();

    // R2 level table
    foreach (LVL_TAB[i]) begin
      clear_reg();
      inv_i = LVL_TAB[i][3];
      link_a_i = ~LVL_TAB[i][2];
      edge_step();
      link_a_i = 1'b1;
      chk(code_at(0) == LVL_TAB[i][1:0], "R2", "stage 0 code", int'(code_at(0)), int'(LVL_TAB[i][1:0]));
      chk(code_at(1) == (inv_i ? 2'b01 : 2'b10), "R2", "stage 1 code", int'(code_at(1)), inv_i ? 1 : 2);
    end

    walk(1'b1);
    walk(1'b0);

    // R5 output-role link ignored
    dir_i = 1'b1; inv_i = 1'b1;
    clear_reg();
    link_b_i = 1'b0;
    edge_step();
    link_b_i = 1'b1;
    chk(count_code(2'b11) == 0, "R5", "link b ignored when output", count_code(2'b11), 0);
    dir_i = 1'b0;
    clear_reg();
    link_a_i = 1'b0;
    edge_step();
    link_a_i = 1'b1;
    chk(count_code(2'b11) == 0, "R5", "link a ignored when output", count_code(2'b11), 0);

    // R7 blanking mid-scan
    dir_i = 1'b1;
    clear_reg();
    link_a_i = 1'b0;
    edge_step();
    link_a_i = 1'b1;
    edge_step();
    chk(code_at(1) == 2'b11, "R3", "token at stage 1", int'(code_at(1)), 3);
    blank_ni = 1'b0;
    #1;
    chk(count_code(2'b00) == N, "R7", "all rows ground", count_code(2'b00), N);
    link_a_i = 1'b0;
    edge_step();
    link_a_i = 1'b1;
    chk(count_code(2'b00) == N && link_b_o, "R7", "held blank over edge", count_code(2'b00), N);
    blank_ni = 1'b1;
    #1;
    // R8 release shows non-select and empty register
    chk(count_code(2'b01) == N, "R8", "non-select after release", count_code(2'b01), N);
    inv_i = 1'b0;
    #1;
    chk(count_code(2'b10) == N, "R8", "non-select other phase", count_code(2'b10), N);
    link_a_i = 1'b0;
    edge_step();
    link_a_i = 1'b1;
    chk(code_at(0) == 2'b00 && count_code(2'b00) == 1, "R8", "capture at next edge", int'(code_at(0)), 0);

    // R1 reset mid-scan
    inv_i = 1'b1;
    edge_step();
    rst_ni = 1'b0;
    #1;
    chk(count_code(2'b11) == 0 && link_a_o && link_b_o, "R1", "reset clears", count_code(2'b11), 0);
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    rst_ni = 1'b1;
    edge_step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule